// File: doc/BRIEF.md
# Padded Vertex Count Generator

This block turns an unsigned vertex count into the padded thread count used when laying out vertex threads. The padded count is always a small odd factor (1, 3, 5, 7 or 9) times a power of two. It is a multiple of four and strictly larger than the count. Choosing it this way wastes fewer threads than rounding up to the next power of two.

A request carries a 32-bit count over a valid/ready handshake. A combinational core finds the leading set bit and the three bits below it, then selects the odd factor and the exponent. The result is registered and offered on a valid/ready response. The response gives the padded count, the odd-factor code `m` and the exponent `s`, so that padded = (2m+1)·2^s. A downstream divider or modulus unit can use the pair directly.

Top module: `padcnt_top`

## Requirements
- R1: Counts 0, 1, 2 and 3 give padded 4, encoded as odd code 0 and shift 2.
- R2: Counts 4–7 give 8 (code 0, shift 3). Counts 8–11 give 12 (code 1, shift 2). Counts 12–15 give 16 (code 0, shift 4). Counts 16–19 give 20 (code 2, shift 2).
- R3: For counts of 20 and above, let k be the number of bits below the top four bits, starting at the leading one. When those top bits are 1000 the result is 9·2^k (code 4, shift k). 1001 gives 5·2^(k+1) (code 2). 101x gives 3·2^(k+2) (code 1). 110x gives 7·2^(k+1) (code 3). 111x gives 2^(k+4) (code 0). The odd code never exceeds 4.
- R4: In every response the padded value equals (2·code+1) shifted left by the shift value. The padded output is 33 bits wide, so a count of 0xFFFFFFFF gives 2^32.
- R5: Every padded value is a multiple of four and strictly greater than the count it answers.
- R6: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high when no response is held or when the held response is being taken. The response for an accepted request is valid from the very next cycle.
- R7: While rsp_valid is high and rsp_ready is low, the response and all its fields stay unchanged.
- R8: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_count | input | 32 | Vertex count |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_padded | output | 33 | Padded count |
| rsp_odd_code | output | 3 | Odd factor code m, factor = 2m+1 |
| rsp_shift | output | 6 | Power-of-two exponent |

## Verification
A wrong leading-one position or a wrong pattern decode shows up in the first response for an affected count, one cycle after acceptance. The usual symptom is a factor of two or a wrong odd factor in the padded value. A bad boundary between the table and the general rule shows up only at counts near 16–23, so those counts are driven explicitly. A corrupted holding register shows up as a changed field during back-pressure, or as a dropped or duplicated response, in the cycle after the stall.

// File: rtl/padcnt_pkg.sv
package padcnt_pkg;

  // Counts below this threshold use the fixed small-count table.
  localparam int unsigned SMALL_LIMIT = 20;

  typedef struct packed {
    logic [2:0] odd;   // m, factor = 2m+1
    logic [2:0] adj;   // exponent (table) or exponent offset (rule)
  } code_t;

  // Small-count table, input below SMALL_LIMIT
  function automatic code_t small_code(input logic [4:0] c);
    code_t r;
    if (c < 5'd4)       r = '{odd: 3'd0, adj: 3'd2};
    else if (c < 5'd8)  r = '{odd: 3'd0, adj: 3'd3};
    else if (c < 5'd12) r = '{odd: 3'd1, adj: 3'd2};
    else if (c < 5'd16) r = '{odd: 3'd0, adj: 3'd4};
    else                r = '{odd: 3'd2, adj: 3'd2};
    return r;
  endfunction

  // Top-four-bit pattern decode for the general rule
  function automatic code_t pattern_code(input logic [3:0] p);
    code_t r;
    casez (p)
      4'b1000: r = '{odd: 3'd4, adj: 3'd0};
      4'b1001: r = '{odd: 3'd2, adj: 3'd1};
      4'b101?: r = '{odd: 3'd1, adj: 3'd2};
      4'b110?: r = '{odd: 3'd3, adj: 3'd1};
      default: r = '{odd: 3'd0, adj: 3'd4};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/padcnt_lead.sv
module padcnt_lead #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  value,
  output logic [PW-1:0] pos,
  output logic          found
);
  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (value[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/padcnt_core.sv
module padcnt_core
  import padcnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SH_W  = $clog2(CNT_W + 1),
  parameter int PAD_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] count,
  output logic [PAD_W-1:0] padded,
  output logic [2:0]       odd_code,
  output logic [SH_W-1:0]  shift,
  output logic             is_small
);
  localparam int PW = $clog2(CNT_W);

  logic [PW-1:0] lead_pos;
  logic          lead_found;
  logic [PW-1:0] low_bits;
  logic [3:0]    top_pat;
  code_t         sc;
  code_t         pc;

  padcnt_lead #(.W(CNT_W), .PW(PW)) lead_i (
    .value (count),
    .pos   (lead_pos),
    .found (lead_found)
  );

  always_comb begin
    is_small = (count < CNT_W'(SMALL_LIMIT)) || !lead_found;
    low_bits = is_small ? '0 : lead_pos - PW'(3);
    top_pat  = 4'(count >> low_bits);
    sc       = small_code(count[4:0]);
    pc       = pattern_code(top_pat);
    if (is_small) begin
      odd_code = sc.odd;
      shift    = SH_W'(sc.adj);
    end else begin
      odd_code = pc.odd;
      shift    = SH_W'(low_bits) + SH_W'(pc.adj);
    end
    padded = PAD_W'({odd_code, 1'b1}) << shift;
  end
endmodule

// File: rtl/padcnt_top.sv
module padcnt_top #(
  parameter int CNT_W = 32,
  parameter int SH_W  = $clog2(CNT_W + 1),
  parameter int PAD_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PAD_W-1:0] rsp_padded,
  output logic [2:0]       rsp_odd_code,
  output logic [SH_W-1:0]  rsp_shift
);
  logic             req_fire;
  logic             rsp_fire;
  logic [PAD_W-1:0] core_padded;
  logic [2:0]       core_odd;
  logic [SH_W-1:0]  core_shift;
  logic             core_small;

  padcnt_core #(.CNT_W(CNT_W), .SH_W(SH_W), .PAD_W(PAD_W)) core_i (
    .count    (req_count),
    .padded   (core_padded),
    .odd_code (core_odd),
    .shift    (core_shift),
    .is_small (core_small)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_padded   <= '0;
      rsp_odd_code <= '0;
      rsp_shift    <= '0;
    end else begin
      if (req_fire) begin
        rsp_valid    <= 1'b1;
        rsp_padded   <= core_padded;
        rsp_odd_code <= core_odd;
        rsp_shift    <= core_shift;
      end else if (rsp_fire) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/padcnt_chk.sv
module padcnt_chk #(
  parameter int CNT_W = 32,
  parameter int SH_W  = $clog2(CNT_W + 1),
  parameter int PAD_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_fire,
  input logic [CNT_W-1:0] req_count,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PAD_W-1:0] rsp_padded,
  input logic [2:0]       rsp_odd_code,
  input logic [SH_W-1:0]  rsp_shift
);
  logic [CNT_W-1:0] held_count;

  always_ff @(posedge clk) begin
    if (!rst_n)        held_count <= '0;
    else if (req_fire) held_count <= req_count;
  end

  AST_ENCODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_padded == (PAD_W'({rsp_odd_code, 1'b1}) << rsp_shift)); // R4

  AST_PAD_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_padded > PAD_W'(held_count)) && (rsp_padded[1:0] == 2'b00)); // R5

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_padded)
      && $stable(rsp_odd_code) && $stable(rsp_shift)); // R7

  AST_ODD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_odd_code <= 3'd4); // R3

  AST_SMALL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_padded >= PAD_W'(4)); // R1
endmodule

bind padcnt_top padcnt_chk #(.CNT_W(CNT_W), .SH_W(SH_W), .PAD_W(PAD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_fire     (req_fire),
  .req_count    (req_count),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_padded   (rsp_padded),
  .rsp_odd_code (rsp_odd_code),
  .rsp_shift    (rsp_shift)
);

// File: tb/padcnt_top_tb_top.sv
module padcnt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_count = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [32:0] rsp_padded;
  logic [2:0]  rsp_odd_code;
  logic [5:0]  rsp_shift;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit stalled = 0;
  longint pend[$];

  always #4 clk = ~clk;  // 125 MHz

  padcnt_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_count(req_count), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_padded(rsp_padded), .rsp_odd_code(rsp_odd_code), .rsp_shift(rsp_shift)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: reduce the count until four bits remain, counting the shifts.
  task automatic ref_calc(input longint c, output int m, output int s);
    longint t;
    int k;
    if (c < 4)       begin m = 0; s = 2; end
    else if (c < 8)  begin m = 0; s = 3; end
    else if (c < 12) begin m = 1; s = 2; end
    else if (c < 16) begin m = 0; s = 4; end
    else if (c < 20) begin m = 2; s = 2; end
    else begin
      t = c; k = 0;
      while (t >= 16) begin t = t / 2; k++; end
      case (t)
        8:       begin m = 4; s = k;     end
        9:       begin m = 2; s = k + 1; end
        10, 11:  begin m = 1; s = k + 2; end
        12, 13:  begin m = 3; s = k + 1; end
        default: begin m = 0; s = k + 4; end
      endcase
    end
  endtask

  task automatic check_rsp();
    longint c, exp_pad, act_pad;
    int m, s;
    string tag;
    chk(rsp_valid == (pend.size() != 0), stalled ? "R7" : "R6",
        longint'(rsp_valid), longint'(pend.size() != 0));
    if (rsp_valid && pend.size() != 0) begin
      c = pend[0];
      ref_calc(c, m, s);
      exp_pad = longint'(2 * m + 1) << s;
      act_pad = longint'(rsp_padded);
      tag = (c < 4) ? "R1" : (c < 20) ? "R2" : "R3";
      if (stalled) tag = "R7";
      chk(act_pad == exp_pad, tag, act_pad, exp_pad);
      chk(int'(rsp_odd_code) == m && int'(rsp_shift) == s, tag,
          longint'(rsp_odd_code) * 100 + longint'(rsp_shift), longint'(m) * 100 + s);
      chk(act_pad == (longint'(2 * rsp_odd_code + 1) << rsp_shift), "R4",
          act_pad, longint'(2 * rsp_odd_code + 1) << rsp_shift);
      chk(act_pad > c && act_pad % 4 == 0, "R5", act_pad, c);
    end
  endtask

  // One cycle: check at negedge, drive, then advance the model for the next edge.
  task automatic step(input bit v, input longint c, input bit rdy);
    bit exp_rdy, in_fire, out_fire;
    @(negedge clk);
    check_rsp();
    req_valid = v; req_count = c[31:0]; rsp_ready = rdy;
    #1;
    exp_rdy = (pend.size() == 0) || rdy;
    chk(req_ready == exp_rdy, "R6", longint'(req_ready), longint'(exp_rdy));
    in_fire  = v && exp_rdy;
    out_fire = (pend.size() != 0) && rdy;
    stalled  = (pend.size() != 0) && !rdy;
    if (out_fire) void'(pend.pop_front());
    if (in_fire)  pend.push_back(c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    longint dir[$] = '{0, 1, 2, 3, 4, 7, 8, 11, 12, 15, 16, 19, 20, 21, 23, 24,
                       31, 32, 70, 71, 72, 127, 128, 144, 160, 192, 224, 255,
                       1000, 65535, 65536, 32'h8000_0000, 32'h9000_0000,
                       32'hA000_0000, 32'hC000_0000, 32'hFFFF_FFFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", longint'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R8", longint'(req_ready), 1);
    rst_n = 1'b1;
    foreach (dir[i]) step(1'b1, dir[i], 1'b1);
    step(1'b0, 0, 1'b1);
    // Back-pressure with directed counts (R7)
    foreach (dir[i]) begin
      step(1'b1, dir[i], 1'b0);
      step(1'b1, 5, 1'b0);
      step(1'b0, 0, 1'b1);
    end
    // Random traffic across all magnitudes
    for (int i = 0; i < 3000; i++) begin
      longint rc;
      rc = longint'($urandom) >> ($urandom % 32);
      step(($urandom % 4) != 0, rc, ($urandom % 3) != 0);
    end
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    finish_run();
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule